// File: doc/BRIEF.md
# Wide Preset Event Down-Counter

This block counts synchronous events against a target that is loaded into it. A load strobe writes the target into a wide register, and each clock edge with the event strobe high lowers the remaining count by one. When the last event brings the count to zero, a registered done pulse appears on that same edge. It is one clock wide. The block then rests at zero until the next load. A 40-bit default width lets a 10 MHz event stream run for more than a day before any wrap. The done pulse always lands within one clock of the final event, which at the 200 MHz design clock is 5 ns, well inside a 100 ns budget.

The register is a chain of 4-bit slices. Each slice steps only when every slice below it shows its terminal value, and all slices change on one shared edge. End of count is found one step early, at a count of one, and that result goes straight into the done flip-flop. A parameter selects a variant that counts upward from the complement of the target and ends at all-ones. Its ports behave exactly like the default.

Events are plain one-cycle strobes with no back-pressure: the block takes every strobe at the edge where it is high and never stalls the source.

Top module: `wide_evt_cnt`

## Requirements
- R1: While reset is high, and on the first edge after it falls with no load, count is 0, busy is 0 and done is 0.
- R2: A load strobe makes count equal the target, busy 1 and done 0 on the next edge. This holds whatever the event strobe, the busy state or the count was in that cycle.
- R3: With busy 1, count nonzero and no load, an edge with the event strobe high lowers count by exactly one. An edge with it low leaves count unchanged.
- R4: The edge at which an event brings count from 1 to 0 also sets done to 1 and busy to 0. Done then stays high for exactly that one cycle.
- R5: A target of zero gives done on the edge after the load edge, with no event needed. Events in between do not change the count.
- R6: With busy 0 and no load, events leave count unchanged (zero after a completed run) and raise neither busy nor done.
- R7: Each load that is not interrupted by another load yields exactly one done pulse.
- R8: The up-counting variant, selected by the direction parameter, shows the same count, busy and done at its ports on every cycle as the default variant.
- R9: A single event propagates a borrow across every 4-bit slice on one edge: 0x01_0000_0000 becomes 0x00_FFFF_FFFF, and 0xFF_FFFF_FFFF becomes 0xFF_FFFF_FFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Writes target_i into the counter; wins over an event |
| target_i | input | W (40) | Number of events to count |
| evt_i | input | 1 | One-cycle event strobe |
| count_o | output | W (40) | Events still to come |
| done_o | output | 1 | One-cycle pulse on the edge the count reaches zero |
| busy_o | output | 1 | High from a load until done |

## Verification
Two functions can collide in one cycle: a fresh load and an event strobe, including a load that arrives while a run is still counting or in the cycle just after done. The bench drives these collisions on purpose in directed steps, and in the random phase it strobes an event with even odds on every load cycle. The result is judged at the ports against a bench model: the loaded target must appear unaltered, with busy high and done low, and the later run must give exactly one done pulse.

// File: rtl/evt_cnt_pkg.sv
`timescale 1ns/1ps
package evt_cnt_pkg;
  typedef enum logic {CNT_DOWN = 1'b0, CNT_UP = 1'b1} cnt_dir_e;

  localparam int SLICE_W = 4;

  function automatic int slices_for(input int width);
    return (width + SLICE_W - 1) / SLICE_W;
  endfunction
endpackage

// File: rtl/evt_cnt_slice.sv
`timescale 1ns/1ps
module evt_cnt_slice #(
  parameter bit UP = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld,
  input  logic [3:0] ld_val,
  input  logic       en,
  output logic [3:0] q,
  output logic       tc
);
  localparam logic [3:0] TERM = UP ? 4'hF : 4'h0;

  always_ff @(posedge clk) begin
    if (rst)      q <= TERM;
    else if (ld)  q <= ld_val;
    else if (en)  q <= UP ? q + 4'd1 : q - 4'd1;
  end

  assign tc = (q == TERM);
endmodule

// File: rtl/evt_cnt_chain.sv
`timescale 1ns/1ps
module evt_cnt_chain #(
  parameter int NS = 10,
  parameter bit UP = 1'b0,
  localparam int PW = NS * 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [PW-1:0] ld_val,
  input  logic          step,
  output logic [PW-1:0] q,
  output logic          all_term,
  output logic          near_end
);
  localparam logic [3:0] NEAR = UP ? 4'hE : 4'h1;

  logic [NS-1:0] tc;
  logic [NS:0]   low_all;   // every slice below index k is terminal
  logic [NS:1]   high_all;  // every slice from 1 up to k-1 is terminal

  assign low_all[0]  = 1'b1;
  assign high_all[1] = 1'b1;

  for (genvar k = 0; k < NS; k++) begin : g_slice
    evt_cnt_slice #(.UP(UP)) u_slice (
      .clk    (clk),
      .rst    (rst),
      .ld     (ld),
      .ld_val (ld_val[k*4 +: 4]),
      .en     (step & low_all[k]),
      .q      (q[k*4 +: 4]),
      .tc     (tc[k])
    );
    assign low_all[k+1] = low_all[k] & tc[k];
    if (k >= 1) begin : g_high
      assign high_all[k+1] = high_all[k] & tc[k];
    end
  end

  assign all_term = low_all[NS];
  assign near_end = (q[3:0] == NEAR) & high_all[NS];
endmodule

// File: rtl/evt_cnt_ctrl.sv
`timescale 1ns/1ps
module evt_cnt_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic evt,
  input  logic all_term,
  input  logic near_end,
  output logic busy,
  output logic done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (load) begin
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy && all_term) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else if (busy && evt && near_end) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/wide_evt_cnt.sv
`timescale 1ns/1ps
module wide_evt_cnt #(
  parameter int W = 40,
  parameter evt_cnt_pkg::cnt_dir_e DIR = evt_cnt_pkg::CNT_DOWN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] target_i,
  input  logic         evt_i,
  output logic [W-1:0] count_o,
  output logic         done_o,
  output logic         busy_o
);
  localparam int NS  = evt_cnt_pkg::slices_for(W);
  localparam int PW  = NS * evt_cnt_pkg::SLICE_W;
  localparam bit UPB = (DIR == evt_cnt_pkg::CNT_UP);

  logic [PW-1:0] tgt_ext, ld_val, q;
  logic          all_term, near_end, step, busy;

  assign tgt_ext = PW'(target_i);
  assign ld_val  = UPB ? ~tgt_ext : tgt_ext;
  assign step    = evt_i & busy & ~load_i & ~all_term;

  evt_cnt_chain #(.NS(NS), .UP(UPB)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .ld       (load_i),
    .ld_val   (ld_val),
    .step     (step),
    .q        (q),
    .all_term (all_term),
    .near_end (near_end)
  );

  evt_cnt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .load     (load_i),
    .evt      (evt_i),
    .all_term (all_term),
    .near_end (near_end),
    .busy     (busy),
    .done     (done_o)
  );

  assign busy_o  = busy;
  assign count_o = UPB ? ~q[W-1:0] : q[W-1:0];
endmodule

// File: rtl/wide_evt_cnt_chk.sv
`timescale 1ns/1ps
module wide_evt_cnt_chk #(
  parameter int W = 40
) (
  input logic         clk,
  input logic         rst,
  input logic         load_i,
  input logic [W-1:0] target_i,
  input logic         evt_i,
  input logic [W-1:0] count_o,
  input logic         done_o,
  input logic         busy_o
);
  p_load_takes_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (busy_o && !done_o && count_o == $past(target_i)));

  p_event_step_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && evt_i && !load_i && count_o != '0) |=> (count_o == $past(count_o) - W'(1)));

  p_no_event_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !evt_i && !load_i && count_o != '0) |=> $stable(count_o));

  p_done_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (count_o == '0 && !busy_o));

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_zero_target_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && count_o == '0 && !load_i) |=> (done_o && count_o == '0));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !load_i) |=> ($stable(count_o) && !busy_o));
endmodule

bind wide_evt_cnt wide_evt_cnt_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load_i   (load_i),
  .target_i (target_i),
  .evt_i    (evt_i),
  .count_o  (count_o),
  .done_o   (done_o),
  .busy_o   (busy_o)
);

// File: tb/wide_evt_cnt_tb_top.sv
`timescale 1ns/1ps
module wide_evt_cnt_tb_top;
  localparam int W = 40;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic [W-1:0] tgt = '0;
  logic         evt = 1'b0;
  logic [W-1:0] cnt_d, cnt_u;
  logic         done_d, done_u, busy_d, busy_u;

  int errors = 0;
  int checks = 0;
  int done_seen = 0;
  bit finished = 1'b0;

  logic [W-1:0] m_cnt  = '0;
  logic         m_busy = 1'b0;
  logic         m_done = 1'b0;

  always #2.5 clk = ~clk;

  wide_evt_cnt #(.W(W), .DIR(evt_cnt_pkg::CNT_DOWN)) dut_i (
    .clk(clk), .rst(rst), .load_i(load), .target_i(tgt), .evt_i(evt),
    .count_o(cnt_d), .done_o(done_d), .busy_o(busy_d));

  wide_evt_cnt #(.W(W), .DIR(evt_cnt_pkg::CNT_UP)) dut_up_i (
    .clk(clk), .rst(rst), .load_i(load), .target_i(tgt), .evt_i(evt),
    .count_o(cnt_u), .done_o(done_u), .busy_o(busy_u));

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "count", 64'(cnt_d), 64'(m_cnt));
    chk(tag, "busy", 64'(busy_d), 64'(m_busy));
    chk(tag, "done", 64'(done_d), 64'(m_done));
    chk("R8", "up count", 64'(cnt_u), 64'(cnt_d));
    chk("R8", "up busy/done", {62'd0, busy_u, done_u}, {62'd0, busy_d, done_d});
  endtask

  // Model of the requirements, advanced once per clock edge.
  task automatic model_step(input logic l, input logic [W-1:0] t, input logic e);
    if (l) begin
      m_cnt = t; m_busy = 1'b1; m_done = 1'b0;
    end else if (m_busy && m_cnt == '0) begin
      m_busy = 1'b0; m_done = 1'b1;
    end else if (m_busy && e && m_cnt == W'(1)) begin
      m_cnt = '0; m_busy = 1'b0; m_done = 1'b1;
    end else if (m_busy && e) begin
      m_cnt = m_cnt - W'(1); m_done = 1'b0;
    end else begin
      m_done = 1'b0;
    end
  endtask

  task automatic cyc(input logic l, input logic [W-1:0] t, input logic e, input string tag);
    load = l; tgt = t; evt = e;
    model_step(l, t, e);
    @(posedge clk); #1;
    check_all(tag);
    if (done_d) done_seen++;
    load = 1'b0; evt = 1'b0;
  endtask

  initial begin
    #950000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    rst = 1'b0;
    cyc(1'b0, '0, 1'b1, "R1");

    // Back-to-back events from a target of 5
    cyc(1'b1, W'(5), 1'b0, "R2");
    for (int i = 0; i < 4; i++) cyc(1'b0, '0, 1'b1, "R3");
    cyc(1'b0, '0, 1'b0, "R3");
    cyc(1'b0, '0, 1'b1, "R4");
    cyc(1'b0, '0, 1'b0, "R4");
    for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, "R6");

    // Zero target with an event strobe in the waiting cycle
    cyc(1'b1, '0, 1'b0, "R5");
    cyc(1'b0, '0, 1'b1, "R5");
    cyc(1'b0, '0, 1'b1, "R6");

    // Load colliding with an event, then a reload mid-run
    cyc(1'b1, W'(7), 1'b1, "R2");
    cyc(1'b0, '0, 1'b1, "R3");
    cyc(1'b1, W'(2), 1'b1, "R2");
    cyc(1'b0, '0, 1'b1, "R3");
    cyc(1'b0, '0, 1'b1, "R4");
    cyc(1'b1, W'(3), 1'b1, "R2");   // load in the cycle after done

    // Borrow across all slices
    cyc(1'b1, 40'h01_0000_0000, 1'b0, "R9");
    cyc(1'b0, '0, 1'b1, "R9");
    cyc(1'b1, 40'hFF_FFFF_FFFF, 1'b0, "R9");
    cyc(1'b0, '0, 1'b1, "R9");

    // Random targets and event spacing
    for (int n = 0; n < 150; n++) begin
      cyc(1'b1, W'($urandom_range(0, 24)), 1'($urandom_range(0, 1)), "R2");
      done_seen = 0;
      for (int g = 0; g < 200 && m_busy; g++)
        cyc(1'b0, '0, ($urandom_range(0, 9) < 6), "R3");
      for (int g = 0; g < 3; g++)
        cyc(1'b0, '0, 1'($urandom_range(0, 1)), "R6");
      chk("R7", "done pulses per load", 64'(done_seen), 64'd1);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule